// File: doc/BRIEF.md
# Dual-Modulus Fractional Tick Generator

This block turns a stream of count-enable strobes into a periodic one-cycle tick whose average spacing can be a fractional number of strobes. A single compare-match counter alternates between two neighbouring terminal values. During a supercycle of M tick periods, the first K periods use the longer terminal value and the remaining M-K periods use the shorter one. The mean divisor is therefore (base+1) + K/M strobes per tick. For example, a 488.28125 Hz strobe divided by 48 + 53/64 yields a 10 Hz tick. Exactly 3125 strobes make one 64-period supercycle.

The integer part (`base_cmp`), the long-period count (`long_cnt`) and the supercycle length (`super_len`) come in on plain input buses. The block only samples them at a supercycle boundary. Software or neighbouring logic can therefore move the average rate slightly up or down by changing the long/short split. The tick never glitches in the middle of a supercycle. Short periods are one strobe shorter than long ones, and this bounded jitter is accepted by design. A `sc_start` flag marks the tick that closes each supercycle.

Top module: `frac_tick_gen`

## Requirements
- R1: While reset is asserted and after its release, `tick` and `sc_start` are low, the counter and period index are zero, and the first period after release is a long one when `long_cnt` is at least 1.
- R2: The counter advances only in cycles where `cnt_en` is high. Without strobes, no tick is produced and the count is held.
- R3: The compare is zero-based and inclusive. A short period lasts `base_cmp`+1 strobes and a long period lasts `base_cmp`+2 strobes.
- R4: Within a supercycle of `super_len` periods, the first `long_cnt` periods are long and the rest are short. With `base_cmp`=47, `long_cnt`=53 and `super_len`=64, this gives 53 periods of 49 strobes and 11 of 48, totalling 3125.
- R5: `tick` is high for one cycle per completed period. It rises in the cycle after the rising clock edge that samples the strobe completing the period.
- R6: `sc_start` is high together with the tick that ends period `super_len` of a supercycle, and at no other time. The period index then returns to zero.
- R7: A `long_cnt` above `super_len` acts as `super_len` (all periods long). A `super_len` of 0 acts as 1.
- R8: The three rate inputs are taken only while the counter and the period index are both zero. Changes at any other time have no effect until the next supercycle boundary.
- R9: A `base_cmp` of 0 with `long_cnt` of 0 makes every strobe a complete period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count-enable strobe from an upstream prescaler |
| base_cmp | input | CNT_W | Short-period compare value (periods last base_cmp+1 strobes) |
| long_cnt | input | IDX_W | Number of long periods at the head of each supercycle |
| super_len | input | IDX_W | Number of periods per supercycle |
| tick | output | 1 | One-cycle pulse at the end of every period |
| sc_start | output | 1 | Pulses with the tick that closes a supercycle |

## Verification
Several properties are checked on every cycle. The count must never pass the active compare value, and the period index must stay below the effective supercycle length. The clamped long count must never exceed that length. A cycle without a strobe must leave count and index unchanged, and a tick must always follow a strobe, with `sc_start` only ever accompanying a tick. The directed scenarios cover what the per-cycle properties cannot show. They check the exact long/short sequence and the 3125-strobe total of the reference rate, and the period lengths under sparse strobes. They also cover the clamping of odd settings, deferral of rate changes to the next boundary, and a restart after a reset arriving mid-period.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  // Period flavour selected for the current tick period
  typedef enum logic {
    PER_SHORT = 1'b0,
    PER_LONG  = 1'b1
  } per_kind_e;

endpackage

// File: rtl/frac_param_hold.sv
// Holds the rate settings for a whole supercycle; live inputs pass through
// only while the block sits at the supercycle origin.
module frac_param_hold #(
  parameter int CNT_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             at_origin,
  input  logic [CNT_W-1:0] base_in,
  input  logic [IDX_W-1:0] k_in,
  input  logic [IDX_W-1:0] m_in,
  output logic [CNT_W-1:0] base_eff,
  output logic [IDX_W-1:0] k_eff,
  output logic [IDX_W-1:0] m_eff
);

  logic [IDX_W-1:0] m_clip;
  logic [IDX_W-1:0] k_clip;

  logic [CNT_W-1:0] base_q, base_d;
  logic [IDX_W-1:0] k_q, k_d;
  logic [IDX_W-1:0] m_q, m_d;

  // Clamp: zero-length supercycle becomes one period, K limited to M
  always_comb begin
    m_clip = (m_in == '0) ? IDX_W'(1) : m_in;
    k_clip = (k_in > m_clip) ? m_clip : k_in;
  end

  always_comb begin
    base_d = base_q;
    k_d    = k_q;
    m_d    = m_q;
    if (at_origin) begin
      base_d = base_in;
      k_d    = k_clip;
      m_d    = m_clip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      k_q    <= '0;
      m_q    <= IDX_W'(1);
    end else begin
      base_q <= base_d;
      k_q    <= k_d;
      m_q    <= m_d;
    end
  end

  always_comb begin
    if (at_origin) begin
      base_eff = base_in;
      k_eff    = k_clip;
      m_eff    = m_clip;
    end else begin
      base_eff = base_q;
      k_eff    = k_q;
      m_eff    = m_q;
    end
  end

endmodule

// File: rtl/frac_period_ctr.sv
// Compare-match counter; terminal value is base or base+1 by period kind.
module frac_period_ctr
  import frac_tick_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] base_eff,
  input  per_kind_e        kind,
  output logic [CMP_W-1:0] cnt,
  output logic [CMP_W-1:0] cmp,
  output logic             wrap
);

  logic [CMP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cmp = {1'b0, base_eff} + ((kind == PER_LONG) ? CMP_W'(1) : CMP_W'(0));
  end

  always_comb begin
    wrap  = cnt_en && (cnt_q == cmp);
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + CMP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/frac_phase_seq.sv
// Period index within the supercycle; picks long or short period.
module frac_phase_seq
  import frac_tick_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [IDX_W-1:0] k_eff,
  input  logic [IDX_W-1:0] m_eff,
  output logic [IDX_W-1:0] idx,
  output per_kind_e        kind,
  output logic             last_per
);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    kind     = (idx_q < k_eff) ? PER_LONG : PER_SHORT;
    last_per = (idx_q == (m_eff - IDX_W'(1)));
  end

  always_comb begin
    idx_d = idx_q;
    if (wrap) begin
      if (last_per) idx_d = '0;
      else          idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 8,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] base_cmp,
  input  logic [IDX_W-1:0] long_cnt,
  input  logic [IDX_W-1:0] super_len,
  output logic             tick,
  output logic             sc_start
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [CNT_W-1:0] base_eff;
  logic [IDX_W-1:0] k_eff;
  logic [IDX_W-1:0] m_eff;
  logic [CMP_W-1:0] cnt;
  logic [CMP_W-1:0] cmp;
  logic [IDX_W-1:0] idx;
  per_kind_e        kind;
  logic             wrap;
  logic             last_per;
  logic             at_origin;

  assign at_origin = (cnt == '0) && (idx == '0);

  frac_param_hold #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .at_origin(at_origin),
    .base_in  (base_cmp),
    .k_in     (long_cnt),
    .m_in     (super_len),
    .base_eff (base_eff),
    .k_eff    (k_eff),
    .m_eff    (m_eff)
  );

  frac_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cnt_en  (cnt_en),
    .base_eff(base_eff),
    .kind    (kind),
    .cnt     (cnt),
    .cmp     (cmp),
    .wrap    (wrap)
  );

  frac_phase_seq #(.IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wrap    (wrap),
    .k_eff   (k_eff),
    .m_eff   (m_eff),
    .idx     (idx),
    .kind    (kind),
    .last_per(last_per)
  );

  // Registered outputs
  logic tick_d, sc_d;

  always_comb begin
    tick_d = wrap;
    sc_d   = wrap && last_per;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      tick     <= 1'b0;
      sc_start <= 1'b0;
    end else begin
      tick     <= tick_d;
      sc_start <= sc_d;
    end
  end

endmodule

// File: rtl/frac_tick_chk.sv
module frac_tick_chk #(
  parameter int CNT_W = 8,
  parameter int IDX_W = 8,
  localparam int CMP_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             tick,
  input logic             sc_start,
  input logic [CMP_W-1:0] cnt,
  input logic [CMP_W-1:0] cmp,
  input logic [IDX_W-1:0] idx,
  input logic [IDX_W-1:0] k_eff,
  input logic [IDX_W-1:0] m_eff
);

  // R2: a tick only follows a cycle carrying a strobe
  a_r2_tick_after_en: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(cnt_en));

  // R2: no strobe, no movement
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(cnt) && $stable(idx)));

  // R3: count never runs past the active terminal value
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cmp);

  // R4: period index stays inside the supercycle
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx < m_eff);

  // R6: supercycle flag only rides on a tick
  a_r6_sc_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sc_start |-> tick);

  // R7: effective settings are clamped
  a_r7_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eff != '0) && (k_eff <= m_eff));

endmodule

bind frac_tick_gen frac_tick_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .cnt_en  (cnt_en),
  .tick    (tick),
  .sc_start(sc_start),
  .cnt     (cnt),
  .cmp     (cmp),
  .idx     (idx),
  .k_eff   (k_eff),
  .m_eff   (m_eff)
);

// File: tb/sim_frac_tick_gen.sv
module sim_frac_tick_gen;

  localparam int CNT_W = 8;
  localparam int IDX_W = 8;

  logic             clk;
  logic             rst_n;
  logic             cnt_en;
  logic [CNT_W-1:0] base_cmp;
  logic [IDX_W-1:0] long_cnt;
  logic [IDX_W-1:0] super_len;
  logic             tick;
  logic             sc_start;

  int n_chk  = 0;
  int n_fail = 0;

  int per [0:255];
  int scf [0:255];

  frac_tick_gen #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .base_cmp (base_cmp),
    .long_cnt (long_cnt),
    .super_len(super_len),
    .tick     (tick),
    .sc_start (sc_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_rate(input int b, input int k, input int m);
    base_cmp  = CNT_W'(b);
    long_cnt  = IDX_W'(k);
    super_len = IDX_W'(m);
  endtask

  task automatic do_reset();
    @(negedge clk);
    cnt_en = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0 && sc_start == 1'b0, "R1 outputs low in reset", {tick, sc_start}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tick == 1'b0 && sc_start == 1'b0, "R1 outputs low after release", {tick, sc_start}, 0);
  endtask

  // Collect n periods (strobe counts) with a strobe every gap cycles
  task automatic collect(input int n, input int gap);
    int pulses = 0;
    int got = 0;
    int cyc = 0;
    while (got < n && cyc < 40000) begin
      cnt_en = ((cyc % gap) == 0);
      @(negedge clk);
      if (cnt_en) pulses++;
      if (tick) begin
        per[got] = pulses;
        scf[got] = int'(sc_start);
        got++;
        pulses = 0;
      end
      cyc++;
    end
    cnt_en = 1'b0;
    chk(got == n, "collect completes", got, n);
  endtask

  task automatic expect_seq(input int n, input int lng, input int k, input int m, input string req);
    int bad = 0;
    int first_bad = -1;
    for (int i = 0; i < n; i++) begin
      int pos = i % m;
      int e   = (pos < k) ? lng : lng - 1;
      int es  = (pos == m - 1) ? 1 : 0;
      if (per[i] != e || scf[i] != es) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (first_bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, per[first_bad] * 10 + scf[first_bad],
             (((first_bad % m) < k) ? lng : lng - 1) * 10 + (((first_bad % m) == m - 1) ? 1 : 0));
  endtask

  task automatic t_reference_rate();
    int sum0 = 0;
    int sum1 = 0;
    set_rate(47, 53, 64);
    do_reset();
    collect(128, 1);
    for (int i = 0; i < 64; i++) sum0 += per[i];
    for (int i = 64; i < 128; i++) sum1 += per[i];
    expect_seq(128, 49, 53, 64, "R4 R3 R6 long/short split 53x49+11x48");
    chk(per[0] == 49, "R1 first period after reset is long", per[0], 49);
    chk(sum0 == 3125, "R4 supercycle total", sum0, 3125);
    chk(sum1 == 3125, "R4 second supercycle total", sum1, 3125);
    chk(per[53] == 48 && per[52] == 49, "R5 one tick per period at switch", per[53], 48);
  endtask

  task automatic t_sparse_and_idle();
    int seen = 0;
    set_rate(3, 2, 5);
    do_reset();
    collect(10, 3);
    expect_seq(10, 5, 2, 5, "R2 R3 sparse strobes");
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    chk(seen == 0, "R2 no tick without strobes", seen, 0);
  endtask

  task automatic t_clamps();
    set_rate(2, 0, 3);
    do_reset();
    collect(3, 1);
    expect_seq(3, 4, 0, 3, "R4 no long periods");
    set_rate(2, 3, 3);
    do_reset();
    collect(3, 1);
    expect_seq(3, 4, 3, 3, "R4 all long periods");
    set_rate(2, 9, 3);
    do_reset();
    collect(3, 1);
    expect_seq(3, 4, 3, 3, "R7 long count above length clamps");
    set_rate(2, 1, 0);
    do_reset();
    collect(2, 1);
    expect_seq(2, 4, 1, 1, "R7 zero length acts as one");
  endtask

  task automatic t_base_zero();
    set_rate(0, 0, 2);
    do_reset();
    collect(4, 2);
    expect_seq(4, 2, 0, 2, "R9 every strobe completes a period");
  endtask

  task automatic t_deferred_change();
    set_rate(3, 1, 4);
    do_reset();
    collect(2, 1);
    chk(per[0] == 5 && per[1] == 4, "R8 old rate before change", per[0] * 10 + per[1], 54);
    set_rate(6, 0, 2);
    collect(2, 1);
    chk(per[0] == 4 && per[1] == 4 && scf[1] == 1, "R8 change deferred to boundary",
        per[0] * 100 + per[1] * 10 + scf[1], 441);
    collect(2, 1);
    chk(per[0] == 7 && per[1] == 7 && scf[1] == 1 && scf[0] == 0, "R8 new rate after boundary",
        per[0] * 100 + per[1] * 10 + scf[1], 771);
  endtask

  task automatic t_reset_mid_period();
    set_rate(5, 1, 3);
    do_reset();
    for (int i = 0; i < 3; i++) begin
      cnt_en = 1'b1;
      @(negedge clk);
    end
    cnt_en = 1'b0;
    do_reset();
    collect(3, 1);
    expect_seq(3, 7, 1, 3, "R1 restart after mid-period reset");
  endtask

  initial begin
    rst_n  = 1'b0;
    cnt_en = 1'b0;
    set_rate(0, 0, 1);
    t_reference_rate();
    t_sparse_and_idle();
    t_clamps();
    t_base_zero();
    t_deferred_change();
    t_reset_mid_period();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule